// File: doc/BRIEF.md
# Gated divided memory-clock generator

This block makes the clock that an external synchronous memory sees during an access. It divides the functional clock by 1, 2, 3 or 4. The clock runs only inside a window that opens a short, programmable delay after the access begins and closes once the programmed access length has elapsed. Outside that window the memory clock is held low. Alongside the clock, a one-cycle strobe in the functional-clock domain marks each cycle in which the memory clock rises. Sequencing logic can use this strobe to launch or capture memory signals without looking at the divided clock.

Four chip selects each have their own divider code and activation-delay code. The caller presents a chip-select index, the access length in functional-clock cycles and a one-cycle start pulse. On the start pulse the block captures the settings of the chosen chip select, together with the access length, and holds them for the whole access. All pins are plain control pins; no data flows through the block, so it has no handshake.

Cycle numbering: cycle 0 is the functional-clock cycle that begins at the rising edge where the start pulse is sampled high. Cycle n begins n rising edges later.

Top module: `mclk_gen`

## Requirements
- R1: Divider code c (0..3) gives a memory-clock period of D = c+1 functional-clock cycles. Inside the window, rising edges of the memory clock fall at the start of cycles A, A+D, A+2D, and so on.
- R2: For D of 2 or more, the memory clock is high for floor(D/2) whole functional cycles and low for the rest of each period. For D = 1, it is high during the first half of every active functional cycle and low during the second half.
- R3: The activation code (0..3) gives a delay A of 0, 1 or 2 cycles. Code 3 acts as 2. No memory-clock high level and no strobe appear in any cycle n < A.
- R4: The window covers cycles A <= n < T, where T is the access length. There is no high level or strobe in cycle T or later, and an access with T <= A produces no clock at all.
- R5: The divider code of chip select i sits at bits [2i+1:2i] of the divider bus, and its activation code sits at the same bits of the activation bus. Only the fields of the chip select named at the start pulse take effect.
- R6: The chip-select index, both code buses and the access length are captured at the start pulse. Changing them during the access has no effect on the clock or the strobe.
- R7: After reset, and in every cycle outside a window, both the memory clock and the strobe are low.
- R8: The strobe is high for exactly those functional cycles at whose start the memory clock rises, i.e. cycles n in the window with (n-A) mod D = 0.
- R9: A start pulse during a running access abandons it. Counting restarts at cycle 0 with the newly selected settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 8 | Divider code per chip select, 2 bits each |
| act_sel | input | 8 | Activation-delay code per chip select, 2 bits each |
| cs_idx | input | 2 | Chip select used by the access being started |
| acc_start | input | 1 | One-cycle pulse that starts an access |
| cyc_time | input | 6 | Access length in functional-clock cycles |
| mem_clk | output | 1 | Gated, divided memory clock |
| mem_clk_en | output | 1 | Strobe, high in cycles where mem_clk rises |

## Verification
The cycle counter or the phase counter can slip. When either does, a rising edge or its strobe moves by at least one functional cycle away from the arithmetic position A + kD, so the fault shows at the ports within one memory-clock period of the window opening. If the captured settings are not held, the next period is visibly wrong right after the stimulus changes. If the window closes late, a high level appears at cycle T, which the bench samples directly. The D = 1 path is checked in both halves of each cycle, because its fault shows only in the high half.

// File: rtl/mclk_gen_pkg.sv
package mclk_gen_pkg;
  localparam int DIV_W = 2;
  localparam int ACT_W = 2;
  localparam int LEN_W = DIV_W + 1;

  // divider code to period length in functional cycles
  function automatic logic [LEN_W-1:0] period_len(input logic [DIV_W-1:0] code);
    return LEN_W'(code) + LEN_W'(1);
  endfunction

  // activation code to delay; the unused top code clamps to 2
  function automatic logic [ACT_W-1:0] act_delay(input logic [ACT_W-1:0] code);
    return (code > ACT_W'(2)) ? ACT_W'(2) : code;
  endfunction
endpackage

// File: rtl/mclk_cfg_pick.sv
module mclk_cfg_pick
  import mclk_gen_pkg::*;
#(
  parameter int NCS  = 4,
  parameter int CS_W = 2
) (
  input  logic [NCS*DIV_W-1:0] div_sel,
  input  logic [NCS*ACT_W-1:0] act_sel,
  input  logic [CS_W-1:0]      cs_idx,
  output logic [LEN_W-1:0]     len_out,
  output logic [ACT_W-1:0]     dly_out
);
  logic [LEN_W-1:0] len_tab [NCS];
  logic [ACT_W-1:0] dly_tab [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign len_tab[g] = period_len(div_sel[g*DIV_W +: DIV_W]);
    assign dly_tab[g] = act_delay(act_sel[g*ACT_W +: ACT_W]);
  end

  always_comb begin
    len_out = LEN_W'(1);
    dly_out = '0;
    for (int i = 0; i < NCS; i++) begin
      if (CS_W'(i) == cs_idx) begin
        len_out = len_tab[i];
        dly_out = dly_tab[i];
      end
    end
  end
endmodule

// File: rtl/mclk_window.sv
module mclk_window
  import mclk_gen_pkg::*;
#(
  parameter int CT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_start,
  input  logic [LEN_W-1:0] len_in,
  input  logic [ACT_W-1:0] dly_in,
  input  logic [CT_W-1:0]  tcyc_in,
  output logic             act_nx,
  output logic             first_nx,
  output logic [LEN_W-1:0] len_nx,
  output logic             busy_q
);
  logic [CT_W-1:0]  cnt_q, cnt_nx;
  logic [CT_W-1:0]  tcyc_q, tcyc_nx;
  logic [LEN_W-1:0] len_q;
  logic [ACT_W-1:0] dly_q, dly_nx;
  logic             busy_nx;

  always_comb begin
    len_nx  = acc_start ? len_in  : len_q;
    dly_nx  = acc_start ? dly_in  : dly_q;
    tcyc_nx = acc_start ? tcyc_in : tcyc_q;
    if (acc_start)   cnt_nx = '0;
    else if (&cnt_q) cnt_nx = cnt_q;
    else             cnt_nx = cnt_q + CT_W'(1);
    busy_nx  = acc_start | (busy_q & (cnt_nx < tcyc_q));
    act_nx   = busy_nx & (cnt_nx >= CT_W'(dly_nx)) & (cnt_nx < tcyc_nx);
    first_nx = (cnt_nx == CT_W'(dly_nx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tcyc_q <= '0;
      len_q  <= LEN_W'(1);
      dly_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      tcyc_q <= tcyc_nx;
      len_q  <= len_nx;
      dly_q  <= dly_nx;
      busy_q <= busy_nx;
    end
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !acc_start && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + CT_W'(1)));

  assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !acc_start) |=> ($stable(len_q) && $stable(dly_q) && $stable(tcyc_q)));

  assert_restart_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> (cnt_q == '0 && busy_q));
endmodule

// File: rtl/mclk_phase.sv
module mclk_phase
  import mclk_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_nx,
  input  logic             first_nx,
  input  logic [LEN_W-1:0] len_nx,
  output logic             div_q,
  output logic             en_q,
  output logic             gate_n
);
  logic [DIV_W-1:0] ph_q, ph_nx;
  logic [LEN_W-1:0] len_q;
  logic             act_q;

  always_comb begin
    if (first_nx)                               ph_nx = '0;
    else if (LEN_W'(ph_q) + LEN_W'(1) >= len_nx) ph_nx = '0;
    else                                        ph_nx = ph_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      len_q <= LEN_W'(1);
      act_q <= 1'b0;
      div_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      ph_q  <= ph_nx;
      len_q <= len_nx;
      act_q <= act_nx;
      div_q <= act_nx & (len_nx != LEN_W'(1)) & (LEN_W'(ph_nx) < (len_nx >> 1));
      en_q  <= act_nx & (ph_nx == '0);
    end
  end

  // divide-by-1 path: enable changes only while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_n <= 1'b0;
    else        gate_n <= act_nx & (len_nx == LEN_W'(1));
  end

  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (LEN_W'(ph_q) < len_q));

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && len_q != LEN_W'(1)) |=> !en_q);

  assert_high_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q && len_q == LEN_W'(2)) |=> !div_q);
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
  import mclk_gen_pkg::*;
#(
  parameter int NCS  = 4,
  parameter int CT_W = 6,
  localparam int CS_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCS*DIV_W-1:0] div_sel,
  input  logic [NCS*ACT_W-1:0] act_sel,
  input  logic [CS_W-1:0]      cs_idx,
  input  logic                 acc_start,
  input  logic [CT_W-1:0]      cyc_time,
  output logic                 mem_clk,
  output logic                 mem_clk_en
);
  logic [LEN_W-1:0] len_pick, len_nx;
  logic [ACT_W-1:0] dly_pick;
  logic             act_nx, first_nx, busy_q;
  logic             div_q, gate_n;

  mclk_cfg_pick #(.NCS(NCS), .CS_W(CS_W)) i_pick (
    .div_sel (div_sel),
    .act_sel (act_sel),
    .cs_idx  (cs_idx),
    .len_out (len_pick),
    .dly_out (dly_pick)
  );

  mclk_window #(.CT_W(CT_W)) i_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_start (acc_start),
    .len_in    (len_pick),
    .dly_in    (dly_pick),
    .tcyc_in   (cyc_time),
    .act_nx    (act_nx),
    .first_nx  (first_nx),
    .len_nx    (len_nx),
    .busy_q    (busy_q)
  );

  mclk_phase i_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_nx   (act_nx),
    .first_nx (first_nx),
    .len_nx   (len_nx),
    .div_q    (div_q),
    .en_q     (mem_clk_en),
    .gate_n   (gate_n)
  );

  // divided path and divide-by-1 path are never active together
  assign mem_clk = (clk & gate_n) | div_q;

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!div_q && !mem_clk_en));

  assert_rise_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_q) |-> mem_clk_en);

  assert_paths_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_q && gate_n));
endmodule

// File: tb/test_mclk_gen.sv
module test_mclk_gen;
  localparam int PER = 20;
  localparam int NCS = 4;
  localparam int CT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] div_sel = '0;
  logic [7:0] act_sel = '0;
  logic [1:0] cs_idx = '0;
  logic acc_start = 1'b0;
  logic [CT_W-1:0] cyc_time = '0;
  logic mem_clk, mem_clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PER/2) clk = ~clk;

  mclk_gen #(.NCS(NCS), .CT_W(CT_W)) i_mclk_gen (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .act_sel(act_sel),
    .cs_idx(cs_idx), .acc_start(acc_start), .cyc_time(cyc_time),
    .mem_clk(mem_clk), .mem_clk_en(mem_clk_en)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  // Entered 1 time unit after a rising edge. Runs one access and checks
  // ncyc cycles from cycle 0; chk_pre also checks the idle cycle before.
  task automatic run(input int cs, input int dc, input int ac, input int t,
                     input int ncyc, input bit chk_pre);
    int d, a;
    d = dc + 1;
    a = (ac > 2) ? 2 : ac;
    for (int i = 0; i < NCS; i++) begin
      div_sel[2*i +: 2] = (i == cs) ? 2'(dc) : 2'(dc + i + 1);
      act_sel[2*i +: 2] = (i == cs) ? 2'(ac) : 2'(ac + 2*i + 1);
    end
    cs_idx = 2'(cs);
    cyc_time = CT_W'(t);
    acc_start = 1'b1;
    #(PER/4 - 1);
    if (chk_pre) begin
      chk("R7", "idle clk hi-half", mem_clk, 1'b0);
      chk("R7", "idle strobe", mem_clk_en, 1'b0);
    end
    #(PER/2);
    if (chk_pre) chk("R7", "idle clk lo-half", mem_clk, 1'b0);
    @(posedge clk);
    #1;
    acc_start = 1'b0;
    // R6: scramble captured inputs after the start pulse
    div_sel = ~div_sel;
    act_sel = ~act_sel;
    cs_idx = cs_idx + 2'd1;
    cyc_time = CT_W'(t + 7);
    for (int n = 0; n < ncyc; n++) begin
      bit actv;
      int p;
      logic hi_e, lo_e, en_e;
      actv = (n >= a) && (n < t);
      p = actv ? (n - a) % d : 0;
      hi_e = actv && (d == 1 || p < d / 2);
      lo_e = actv && d > 1 && p < d / 2;
      en_e = actv && p == 0;
      #(PER/4 - 1);
      chk((n < a) ? "R3" : ((n >= t) ? "R4" : "R1"), "clk hi-half", mem_clk, hi_e);
      chk("R8", "strobe", mem_clk_en, en_e);
      #(PER/2);
      chk((d == 1) ? "R2" : "R1", "clk lo-half", mem_clk, lo_e);
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    int tl [7] = '{0, 1, 2, 3, 4, 7, 10};
    #(PER*3 + 3);
    chk("R7", "reset clk", mem_clk, 1'b0);
    chk("R7", "reset strobe", mem_clk_en, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R1 R2 R3 R4 R5 R6 R8: sweep of chip select, divider, delay and length
    for (int cs = 0; cs < NCS; cs++)
      for (int dc = 0; dc < 4; dc++)
        for (int ac = 0; ac < 4; ac++)
          for (int k = 0; k < 7; k++)
            run(cs, dc, ac, tl[k], tl[k] + 3, 1'b1);
    // R9: restart while running, with a different chip select and divider
    run(1, 3, 1, 40, 6, 1'b1);
    run(2, 1, 0, 9, 12, 1'b0);
    run(0, 0, 2, 30, 5, 1'b1);
    run(3, 2, 1, 11, 14, 1'b0);
    // R4: long access near the counter limit
    run(0, 3, 0, 63, 66, 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PER*150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule